// File: doc/BRIEF.md
# Byte-serial register port with split read and write word spaces

This block sits between a host that moves one byte per strobe and a set of internal registers. The host first loads a byte address. After that, each read strobe or write strobe moves one byte, and the address then advances by one. Reads and writes use separate spaces that share the same address counter. Read words are four bytes wide and write words are two bytes wide. In both spaces the least significant byte of a word sits at the lowest address.

On the read side there are five status words. The first four carry the 21-bit step position counters, one per axis. The fifth carries the 16 digital inputs. When byte 0 of a read word is taken, the whole word is captured at that moment, so bytes 1 to 3 always belong to the same value. On the write side the low byte of a word is held in a staging register. The target register changes only when the high byte arrives, so the update is atomic. The write words drive four velocity fields, the digital output field and a timing word. The timing word carries the step pulse time, the direction setup/hold time, a common step polarity and a watchdog kick. The kick leaves the block as a single-cycle pulse.

Top module: `byte_reg_port`

## Requirements
- R1: After reset the byte address is 0, host_dout is 0, all velocity, digital output, timing and polarity outputs are 0, and wdog_kick is 0.
- R2: When addr_load is high in a cycle, the byte address becomes host_din and any strobe in that cycle is ignored. Otherwise, each cycle with rd_stb or wr_stb high adds one to the address, wrapping modulo 256.
- R3: A read strobe at byte address a loads host_dout, in that clock edge, with byte a mod 4 of read word a/4. Word n for n = 0..3 holds position n in bits 20:0. Word 4 holds the digital inputs in bits 15:0. All other bits, and all words from 5 upward, read as 0. host_dout holds its value in cycles without rd_stb.
- R4: Bytes 1 to 3 of a read word come from the value the word had when its byte 0 was read, even if the inputs have changed since then.
- R5: A write strobe at an even address only stages the byte. No output changes in response to it.
- R6: A write strobe at an odd address a commits the 16-bit word {host_din, staged byte} to write word a/2. Word n for n = 0..3 sets velocity n from bits 11:0. Word 4 sets the digital outputs from bits 13:0. Word 5 sets step_time from bits 3:0, dir_time from bits 11:8 and step_pol from bit 15.
- R7: A commit of word 5 with bit 14 set drives wdog_kick high for exactly the one cycle after the commit edge. A commit with bit 14 clear produces no pulse.
- R8: Bits of a committed word that lie outside the fields in R6 have no effect on any output.
- R9: Commits to write words 6 and above change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load the byte address from host_din |
| rd_stb | input | 1 | Read one byte at the current address |
| wr_stb | input | 1 | Write host_din at the current address |
| host_din | input | 8 | Host byte (write data or address) |
| host_dout | output | 8 | Last byte read |
| pos_in | input | 84 | Four 21-bit position values, axis 0 in the low bits |
| dig_in | input | 16 | Digital inputs |
| vel_out | output | 48 | Four 12-bit velocity fields, axis 0 in the low bits |
| dig_out | output | 14 | Digital outputs |
| step_time | output | 4 | Step pulse time setting |
| dir_time | output | 4 | Direction setup/hold time setting |
| step_pol | output | 1 | Common step polarity |
| wdog_kick | output | 1 | One-cycle watchdog enable/kick pulse |

## Verification
A wrong address counter shows up within one strobe: the next byte read returns a neighbouring field, or the next write commits to the wrong register. A corrupted staging register shows up only when the high byte of the same word commits, because that is when a wrong low byte reaches the outputs. A broken snapshot shows up only if the inputs change between byte 0 and the later bytes of a read word, so the bench changes positions deliberately in the middle of a word. Kick faults can be seen in the single cycle after a timing-word commit, and the bench samples exactly that cycle and the one after it.

// File: rtl/bport_pkg.sv
package bport_pkg;
  localparam int RD_WORD_BYTES = 4;
  localparam int WR_WORD_BYTES = 2;
  localparam int KICK_BIT      = 14;
  localparam int POL_BIT       = 15;
  localparam int DIR_LSB       = 8;

  typedef struct packed {
    logic [3:0] step_t;
    logic [3:0] dir_t;
    logic       pol;
    logic       kick;
  } timing_t;

  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] k);
    return w[8*k +: 8];
  endfunction

  function automatic timing_t decode_timing(input logic [15:0] w);
    timing_t t;
    t.step_t = w[3:0];
    t.dir_t  = w[DIR_LSB +: 4];
    t.pol    = w[POL_BIT];
    t.kick   = w[KICK_BIT];
    return t;
  endfunction
endpackage

// File: rtl/bport_addr_ctr.sv
module bport_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/bport_rd_unpack.sv
module bport_rd_unpack
  import bport_pkg::*;
#(
  parameter int NUM_AXES = 4,
  parameter int POS_W    = 21,
  parameter int DIN_W    = 16,
  parameter int ADDR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_fire,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_AXES*POS_W-1:0] pos_flat,
  input  logic [DIN_W-1:0]          din,
  output logic [7:0]                dout
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [1:0]        bsel;
  logic [31:0]       live_word;
  logic [31:0]       snap_q;
  logic              first_byte;

  assign widx       = addr[ADDR_W-1:2];
  assign bsel       = addr[1:0];
  assign first_byte = (bsel == 2'd0);

  always_comb begin
    live_word = '0;
    for (int n = 0; n < NUM_AXES; n++) begin
      if (widx == WIDX_W'(n)) live_word[POS_W-1:0] = pos_flat[n*POS_W +: POS_W];
    end
    if (widx == WIDX_W'(NUM_AXES)) live_word[DIN_W-1:0] = din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      dout   <= '0;
    end else if (rd_fire) begin
      if (first_byte) begin
        snap_q <= live_word;
        dout   <= byte_of(live_word, 2'd0);
      end else begin
        dout   <= byte_of(snap_q, bsel);
      end
    end
  end
endmodule

// File: rtl/bport_wr_pack.sv
module bport_wr_pack
  import bport_pkg::*;
#(
  parameter int NUM_AXES = 4,
  parameter int VEL_W    = 12,
  parameter int DOUT_W   = 14,
  parameter int ADDR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_fire,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                data,
  output logic [NUM_AXES*VEL_W-1:0] vel_flat,
  output logic [DOUT_W-1:0]         dout,
  output logic [3:0]                step_t,
  output logic [3:0]                dir_t,
  output logic                      pol,
  output logic                      kick,
  output logic                      commit_evt
);
  localparam int WIDX_W   = ADDR_W - 1;
  localparam int DOUT_IDX = NUM_AXES;
  localparam int TIME_IDX = NUM_AXES + 1;

  logic [7:0]        stage_q;
  logic [15:0]       word;
  logic [WIDX_W-1:0] widx;
  timing_t           tdec;

  assign widx       = addr[ADDR_W-1:1];
  assign commit_evt = wr_fire && addr[0];
  assign word       = {data, stage_q};
  assign tdec       = decode_timing(word);

  always_ff @(posedge clk) begin
    if (!rst_n)                  stage_q <= '0;
    else if (wr_fire && !addr[0]) stage_q <= data;
  end

  for (genvar n = 0; n < NUM_AXES; n++) begin : g_vel
    always_ff @(posedge clk) begin
      if (!rst_n) vel_flat[n*VEL_W +: VEL_W] <= '0;
      else if (commit_evt && widx == WIDX_W'(n))
        vel_flat[n*VEL_W +: VEL_W] <= word[VEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout   <= '0;
      step_t <= '0;
      dir_t  <= '0;
      pol    <= 1'b0;
      kick   <= 1'b0;
    end else begin
      kick <= 1'b0;
      if (commit_evt && widx == WIDX_W'(DOUT_IDX)) dout <= word[DOUT_W-1:0];
      if (commit_evt && widx == WIDX_W'(TIME_IDX)) begin
        step_t <= tdec.step_t;
        dir_t  <= tdec.dir_t;
        pol    <= tdec.pol;
        kick   <= tdec.kick;
      end
    end
  end
endmodule

// File: rtl/byte_reg_port.sv
module byte_reg_port #(
  parameter int NUM_AXES = 4,
  parameter int POS_W    = 21,
  parameter int VEL_W    = 12,
  parameter int DIN_W    = 16,
  parameter int DOUT_W   = 14,
  parameter int ADDR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      addr_load,
  input  logic                      rd_stb,
  input  logic                      wr_stb,
  input  logic [7:0]                host_din,
  output logic [7:0]                host_dout,
  input  logic [NUM_AXES*POS_W-1:0] pos_in,
  input  logic [DIN_W-1:0]          dig_in,
  output logic [NUM_AXES*VEL_W-1:0] vel_out,
  output logic [DOUT_W-1:0]         dig_out,
  output logic [3:0]                step_time,
  output logic [3:0]                dir_time,
  output logic                      step_pol,
  output logic                      wdog_kick
);
  logic [ADDR_W-1:0] addr_q;
  logic              rd_fire;
  logic              wr_fire;
  logic              commit_evt;

  assign rd_fire = rd_stb && !addr_load;
  assign wr_fire = wr_stb && !addr_load;

  bport_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load),
    .load_val(ADDR_W'(host_din)), .step(rd_fire || wr_fire), .addr(addr_q)
  );

  bport_rd_unpack #(.NUM_AXES(NUM_AXES), .POS_W(POS_W), .DIN_W(DIN_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .addr(addr_q),
    .pos_flat(pos_in), .din(dig_in), .dout(host_dout)
  );

  bport_wr_pack #(.NUM_AXES(NUM_AXES), .VEL_W(VEL_W), .DOUT_W(DOUT_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr(addr_q), .data(host_din),
    .vel_flat(vel_out), .dout(dig_out), .step_t(step_time), .dir_t(dir_time),
    .pol(step_pol), .kick(wdog_kick), .commit_evt(commit_evt)
  );
endmodule

// File: rtl/bport_chk.sv
module bport_chk #(
  parameter int NUM_AXES = 4,
  parameter int VEL_W    = 12,
  parameter int DOUT_W   = 14,
  parameter int ADDR_W   = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      addr_load,
  input logic                      rd_stb,
  input logic                      wr_stb,
  input logic [7:0]                host_din,
  input logic [ADDR_W-1:0]         addr_q,
  input logic [7:0]                host_dout,
  input logic [NUM_AXES*VEL_W-1:0] vel_out,
  input logic [DOUT_W-1:0]         dig_out,
  input logic                      step_pol,
  input logic                      commit_evt,
  input logic                      wdog_kick
);
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && (rd_stb || wr_stb)) |=> addr_q == $past(addr_q) + 1'b1);

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> addr_q == ADDR_W'($past(host_din)));

  assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(host_dout));

  assert_stage_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> ($stable(vel_out) && $stable(dig_out) && $stable(step_pol)));

  assert_kick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_kick |=> !wdog_kick);

  assert_kick_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_kick |-> ($past(wr_stb) && !$past(addr_load) && $past(addr_q) == ADDR_W'(11)
                   && $past(host_din[6])));
endmodule

bind byte_reg_port bport_chk #(
  .NUM_AXES(NUM_AXES), .VEL_W(VEL_W), .DOUT_W(DOUT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .host_din(host_din), .addr_q(addr_q), .host_dout(host_dout), .vel_out(vel_out),
  .dig_out(dig_out), .step_pol(step_pol), .commit_evt(commit_evt), .wdog_kick(wdog_kick)
);

// File: tb/byte_reg_port_tb.sv
module byte_reg_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_load, rd_stb, wr_stb;
  logic [7:0]  host_din, host_dout;
  logic [83:0] pos_in;
  logic [15:0] dig_in;
  logic [47:0] vel_out;
  logic [13:0] dig_out;
  logic [3:0]  step_time, dir_time;
  logic        step_pol, wdog_kick;

  int checks = 0;
  int errors = 0;

  logic [11:0] vel_m [4];
  logic [13:0] dout_m;
  logic [3:0]  st_m, dt_m;
  logic        pol_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .host_din(host_din), .host_dout(host_dout), .pos_in(pos_in), .dig_in(dig_in),
    .vel_out(vel_out), .dig_out(dig_out), .step_time(step_time), .dir_time(dir_time),
    .step_pol(step_pol), .wdog_kick(wdog_kick)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_word(input int n, input logic [83:0] p, input logic [15:0] d);
    if (n < 4) return {11'd0, p[n*21 +: 21]};
    if (n == 4) return {16'd0, d};
    return 32'd0;
  endfunction

  function automatic logic [47:0] vel_flat_m();
    return {vel_m[3], vel_m[2], vel_m[1], vel_m[0]};
  endfunction

  task automatic model_commit(input int n, input logic [15:0] w);
    if (n < 4) vel_m[n] = w[11:0];
    else if (n == 4) dout_m = w[13:0];
    else if (n == 5) begin st_m = w[3:0]; dt_m = w[11:8]; pol_m = w[15]; end
  endtask

  task automatic check_outs(input string tag);
    chk(tag, vel_out, vel_flat_m());
    chk(tag, {step_pol, dir_time, step_time, dig_out}, {pol_m, dt_m, st_m, dout_m});
  endtask

  task automatic cyc(input logic ld, input logic rd, input logic wr, input logic [7:0] d);
    addr_load = ld; rd_stb = rd; wr_stb = wr; host_din = d;
    @(posedge clk); @(negedge clk);
    addr_load = 0; rd_stb = 0; wr_stb = 0;
  endtask

  task automatic wr_word(input int n, input logic [15:0] w, input string tag);
    cyc(1, 0, 0, 8'(2*n));
    cyc(0, 0, 1, w[7:0]);
    check_outs("R5 low byte staged only");
    cyc(0, 0, 1, w[15:8]);
    model_commit(n, w);
    chk("R7 kick in cycle after commit", wdog_kick, (n == 5) && w[14]);
    check_outs(tag);
    @(negedge clk);
    chk("R7 kick lasts one cycle", wdog_kick, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] w, old;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; addr_load = 0; rd_stb = 0; wr_stb = 0; host_din = 0;
    pos_in = '0; dig_in = '0;
    for (int i = 0; i < 4; i++) vel_m[i] = '0;
    dout_m = '0; st_m = '0; dt_m = '0; pol_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 host_dout reset", host_dout, 0);
    chk("R1 kick reset", wdog_kick, 0);
    check_outs("R1 outputs reset");
    cyc(0, 1, 0, 0);
    chk("R1 address starts at 0", host_dout, 0);

    wr_word(2, 16'hFABC, "R8 velocity upper bits ignored");
    wr_word(4, 16'hFFFF, "R8 digital output bits 15:14 ignored");
    wr_word(5, 16'hC5A3, "R6 timing word with kick");
    wr_word(5, 16'h0F0F, "R6 timing word without kick");
    wr_word(6, 16'hFFFF, "R9 word 6 ignored");
    wr_word(7, 16'hFFFF, "R9 word 7 ignored");

    // R2: addr_load wins over a simultaneous write strobe
    cyc(1, 0, 1, 8'd0);
    cyc(0, 0, 1, 8'h11);
    cyc(0, 0, 1, 8'h02);
    model_commit(0, 16'h0211);
    check_outs("R2 load suppresses strobe, then increments");

    // R3: sweep all read bytes 0..23 in one burst with auto increment
    for (int i = 0; i < 4; i++) pos_in[i*21 +: 21] = 21'($urandom);
    dig_in = 16'($urandom);
    cyc(1, 0, 0, 8'd0);
    for (int a = 0; a < 24; a++) begin
      cyc(0, 1, 0, 8'd0);
      chk("R3 read byte mapping", host_dout, rd_word(a/4, pos_in, dig_in)[8*(a%4) +: 8]);
    end
    @(negedge clk);
    chk("R3 host_dout holds", host_dout, 8'd0);

    // R4: snapshot across a mid-word input change
    pos_in[21 +: 21] = 21'h1A_BCDE;
    old = rd_word(1, pos_in, dig_in);
    cyc(1, 0, 0, 8'd4);
    cyc(0, 1, 0, 8'd0);
    chk("R4 byte 0 live", host_dout, old[7:0]);
    pos_in[21 +: 21] = 21'h05_4321;
    for (int b = 1; b < 4; b++) begin
      cyc(0, 1, 0, 8'd0);
      chk("R4 snapshot byte", host_dout, old[8*b +: 8]);
    end

    // R2: address wrap from 255 to 0
    cyc(1, 0, 0, 8'hFF);
    cyc(0, 1, 0, 8'd0);
    cyc(0, 1, 0, 8'd0);
    chk("R2 address wraps to 0", host_dout, rd_word(0, pos_in, dig_in)[7:0]);

    // random writes and reads
    for (int it = 0; it < 40; it++) begin
      int n;
      n = int'($urandom % 8);
      wr_word(n, 16'($urandom), "R6 random commit");
      pos_in = {20'($urandom), 32'($urandom), 32'($urandom)};
      dig_in = 16'($urandom);
      n = int'($urandom % 6);
      w = rd_word(n, pos_in, dig_in);
      cyc(1, 0, 0, 8'(4*n));
      for (int b = 0; b < 4; b++) begin
        cyc(0, 1, 0, 8'd0);
        chk("R3 random read", host_dout, w[8*b +: 8]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule